// File: doc/BRIEF.md
# Washer Cycle Controller

This block sequences one washing cycle through five phases: waiting, filling the tub, agitating, pumping out, and a final spin-dry, then back to waiting. It reads a start request, a tub-full sensor and a tub-empty sensor. A built-in down-counting interval timer measures how long the agitate and spin-dry phases last. The block drives a water valve, a spin motor, a drain pump and a timer-reload strobe.

Each of the four drive outputs and the phase code comes straight from a flip-flop. The value of each output register is worked out from the phase that the machine is about to enter. As a result, a registered output changes in the same cycle as the phase it belongs to, with no extra cycle of lag.

The reload strobe stays high for every cycle the machine is filling or draining. The timer therefore holds its full count at the moment either phase ends. Both timed phases share one duration parameter, `WAIT_CYCLES`.

Top module: `washer_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to the waiting phase (code 0). It clears all four drive outputs and empties the timer, so `timeout_o` reads 1.
- R2: In the waiting phase (code 0) all drive outputs are 0. A 1 on `start_i` moves the machine to filling (code 1) at the next edge. Otherwise it stays waiting.
- R3: In the filling phase (code 1), `water_o`=1 and `tload_o`=1 on every cycle, and the other outputs are 0. The machine stays in filling while `full_i`=0 and goes to agitate (code 2) at the edge that samples `full_i`=1.
- R4: In the agitate phase (code 2), only `spin_o` is 1. The machine goes to pump-out (code 3) at the edge that samples `timeout_o`=1.
- R5: In the pump-out phase (code 3), `drain_o`=1 and `tload_o`=1 on every cycle. The machine stays while `empty_i`=0 and goes to spin-dry (code 4) at the edge that samples `empty_i`=1.
- R6: In the spin-dry phase (code 4), `spin_o` and `drain_o` are both 1. The machine returns to waiting at the edge that samples `timeout_o`=1.
- R7: The drive outputs and `phase_o` are registered and change at the same edge. An output never lags or leads the phase it belongs to.
- R8: An edge with `tload_o`=1 sets the timer to `WAIT_CYCLES`. Each other edge lowers a nonzero timer by one. `timeout_o` is 1 exactly when the timer is zero. As a result, agitate and spin-dry each last `WAIT_CYCLES`+1 cycles.
- R9: A sensor or start input that does not belong to the current phase has no effect on the phase or the outputs. This covers `start_i` outside waiting, `full_i` outside filling, and `empty_i` outside pump-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a cycle |
| full_i | input | 1 | Tub-full sensor |
| empty_i | input | 1 | Tub-empty sensor |
| water_o | output | 1 | Water valve on |
| spin_o | output | 1 | Spin motor on |
| drain_o | output | 1 | Drain pump on |
| tload_o | output | 1 | Interval timer reload strobe |
| timeout_o | output | 1 | Interval timer at zero |
| phase_o | output | 3 | Current phase code (0 waiting, 1 filling, 2 agitate, 3 pump-out, 4 spin-dry) |

## Verification
A sensor or start value is sampled at the next rising edge. The new phase and all its outputs are visible together right after that one edge. `timeout_o` falls one edge after the last reload cycle and rises again `WAIT_CYCLES` edges later. The timed phases therefore exit `WAIT_CYCLES`+1 cycles after they are entered.

The bench drives inputs on the falling edge and steps its own arithmetic phase-and-timer model once per cycle. It compares every output on the next falling edge, which is exactly one register after the inputs were applied. It sweeps the waiting gap, the fill length and the drain length, each with and without stray input activity. It also measures the timed phase lengths straight from `phase_o`.

// File: rtl/washer_pkg.sv
// Shared types for the washer cycle controller.
// Assumes a 3-bit binary phase code; codes 5..7 are illegal.
package washer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FILL  = 3'd1,
        PH_WASH  = 3'd2,
        PH_DRAIN = 3'd3,
        PH_WRING = 3'd4
    } phase_e;

    typedef struct packed {
        logic water;
        logic spin;
        logic drain;
        logic tload;
    } drive_t;

endpackage

// File: rtl/wash_out_decode.sv
// Maps a phase code to the drive pattern that phase requires.
// Purely combinational. Any illegal code yields all outputs low.
module wash_out_decode
    import washer_pkg::*;
(
    input  phase_e phase_i,
    output drive_t drv_o
);

    // Drive pattern per phase
    always_comb begin
        drv_o = '0;
        case (phase_i)
            PH_FILL:  begin drv_o.water = 1'b1; drv_o.tload = 1'b1; end
            PH_WASH:  begin drv_o.spin  = 1'b1; end
            PH_DRAIN: begin drv_o.drain = 1'b1; drv_o.tload = 1'b1; end
            PH_WRING: begin drv_o.spin  = 1'b1; drv_o.drain = 1'b1; end
            default:  drv_o = '0;
        endcase
    end

endmodule

// File: rtl/wash_interval_timer.sv
// Down-counting interval timer. Reload sets WAIT_CYCLES; otherwise the
// count falls to zero and holds. timeout_o is high while at zero.
// Assumes WAIT_CYCLES >= 1 and a synchronous active-low reset.
module wash_interval_timer #(
    parameter int WAIT_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic timeout_o
);

    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count register: reload, decrement or hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Zero detect
    assign timeout_o = (cnt_q == '0);

    // R8
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == LOAD_VAL);

    // R8
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/wash_ctrl_fsm.sv
// Phase sequencer with registered outputs. Output registers load the
// pattern of the phase being entered, so they switch together with the
// phase register. Assumes timeout_i is a registered timer flag.
module wash_ctrl_fsm
    import washer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   full_i,
    input  logic   empty_i,
    input  logic   timeout_i,
    output phase_e phase_o,
    output drive_t drv_o
);

    phase_e phase_q, phase_d;
    drive_t drv_q, drv_d;

    // Next phase selection
    always_comb begin
        phase_d = PH_IDLE;
        case (phase_q)
            PH_IDLE:  phase_d = start_i   ? PH_FILL  : PH_IDLE;
            PH_FILL:  phase_d = full_i    ? PH_WASH  : PH_FILL;
            PH_WASH:  phase_d = timeout_i ? PH_DRAIN : PH_WASH;
            PH_DRAIN: phase_d = empty_i   ? PH_WRING : PH_DRAIN;
            PH_WRING: phase_d = timeout_i ? PH_IDLE  : PH_WRING;
            default:  phase_d = PH_IDLE;
        endcase
    end

    wash_out_decode u_decode (
        .phase_i (phase_d),
        .drv_o   (drv_d)
    );

    // Phase and output registers, loaded together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            drv_q   <= '0;
        end else begin
            phase_q <= phase_d;
            drv_q   <= drv_d;
        end
    end

    assign phase_o = phase_q;
    assign drv_o   = drv_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !start_i) |=> phase_q == PH_IDLE);

    // R3
    fill_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FILL && full_i) |=> phase_q == PH_WASH);

    // R5
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DRAIN && empty_i) |=> phase_q == PH_WRING);

    // R6
    wring_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WRING && timeout_i) |=> phase_q == PH_IDLE);

    // R7
    strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.tload == (phase_q == PH_FILL || phase_q == PH_DRAIN));

    // R7
    water_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.water == (phase_q == PH_FILL));

endmodule

// File: rtl/washer_cycle_ctrl.sv
// Top of the washer cycle controller: phase sequencer plus interval
// timer fed by the registered reload strobe.
// Assumes synchronous inputs and a synchronous active-low reset.
module washer_cycle_ctrl
    import washer_pkg::*;
#(
    parameter int WAIT_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       full_i,
    input  logic       empty_i,
    output logic       water_o,
    output logic       spin_o,
    output logic       drain_o,
    output logic       tload_o,
    output logic       timeout_o,
    output logic [2:0] phase_o
);

    phase_e phase_w;
    drive_t drv_w;
    logic   tmo_w;

    wash_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .full_i    (full_i),
        .empty_i   (empty_i),
        .timeout_i (tmo_w),
        .phase_o   (phase_w),
        .drv_o     (drv_w)
    );

    wash_interval_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (drv_w.tload),
        .timeout_o (tmo_w)
    );

    // Port mapping
    assign water_o   = drv_w.water;
    assign spin_o    = drv_w.spin;
    assign drain_o   = drv_w.drain;
    assign tload_o   = drv_w.tload;
    assign timeout_o = tmo_w;
    assign phase_o   = phase_w;

endmodule

// File: tb/washer_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module washer_cycle_ctrl_tb_top;

    localparam int W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, full_i = 1'b0, empty_i = 1'b0;
    logic water_o, spin_o, drain_o, tload_o, timeout_o;
    logic [2:0] phase_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model state
    int ph_m = 0;
    int tcnt_m = 0;

    always #10 clk = ~clk;

    washer_cycle_ctrl #(.WAIT_CYCLES(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_i(full_i),
        .empty_i(empty_i), .water_o(water_o), .spin_o(spin_o),
        .drain_o(drain_o), .tload_o(tload_o), .timeout_o(timeout_o),
        .phase_o(phase_o)
    );

    function automatic string tag_of(int ph, bit noise);
        if (noise) return "R9 R7";
        case (ph)
            0: return "R2 R7";
            1: return "R3 R7";
            2: return "R4 R8";
            3: return "R5 R7";
            default: return "R6 R8";
        endcase
    endfunction

    task automatic check_now(string tag);
        logic [7:0] act, exp;
        act = {phase_o, water_o, spin_o, drain_o, tload_o, timeout_o};
        exp = {3'(ph_m), ph_m == 1, (ph_m == 2 || ph_m == 4),
               (ph_m == 3 || ph_m == 4), (ph_m == 1 || ph_m == 3), tcnt_m == 0};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {phase,water,spin,drain,tload,timeout} got %b expected %b",
                     tag, act, exp);
        end
    endtask

    task automatic check_len(string tag, int got, int want);
        n_run++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: phase length got %0d expected %0d", tag, got, want);
        end
    endtask

    // One full cycle; inputs applied at falling edges, model stepped alongside
    task automatic run_scn(int gap, int flen, int dlen, bit noise);
        int dwell = 0;
        int wash_len = 0;
        int wring_len = 0;
        for (int k = 0; k < 200; k++) begin
            bit st, fl, em, to;
            int nph;
            @(negedge clk);
            check_now(tag_of(ph_m, noise));
            if (phase_o == 3'd2) wash_len++;
            if (phase_o == 3'd4) wring_len++;
            st = (ph_m == 0 && dwell >= gap);
            fl = (ph_m == 1 && dwell >= flen);
            em = (ph_m == 3 && dwell >= dlen);
            if (noise) begin
                if (ph_m != 0) st = 1'b1;
                if (ph_m != 1) fl = 1'b1;
                if (ph_m != 3) em = 1'b1;
            end
            start_i = st; full_i = fl; empty_i = em;
            to = (tcnt_m == 0);
            case (ph_m)
                0: nph = st ? 1 : 0;
                1: nph = fl ? 2 : 1;
                2: nph = to ? 3 : 2;
                3: nph = em ? 4 : 3;
                default: nph = to ? 0 : 4;
            endcase
            if (ph_m == 1 || ph_m == 3) tcnt_m = W;
            else if (tcnt_m > 0) tcnt_m--;
            dwell = (nph == ph_m) ? dwell + 1 : 0;
            if (ph_m == 4 && nph == 0) begin
                ph_m = nph;
                @(negedge clk);
                start_i = 1'b0; full_i = 1'b0; empty_i = 1'b0;
                check_now(noise ? "R9 R6" : "R6");
                if (tcnt_m > 0) tcnt_m--;
                // R8: timed phases last WAIT_CYCLES+1 cycles
                check_len("R8 wash", wash_len, W + 1);
                check_len("R8 wring", wring_len, W + 1);
                return;
            end
            ph_m = nph;
        end
        n_run++; n_fail++;
        $display("FAIL R6: cycle did not return to idle");
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        ph_m = 0; tcnt_m = 0;
        check_now("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 R2");

        for (int g = 0; g < 3; g++)
            for (int f = 0; f < 4; f++)
                for (int d = 0; d < 4; d++)
                    for (int nz = 0; nz < 2; nz++)
                        run_scn(g, f, d, nz[0]);

        // R1: reset in the middle of a cycle (during fill)
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ph_m = 1; tcnt_m = (tcnt_m > 0) ? tcnt_m - 1 : 0;
        check_now("R3");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ph_m = 0; tcnt_m = 0;
        check_now("R1");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule